// File: doc/BRIEF.md
# Divide-by-8 Clock Divider with Shift-Register Counter

This block makes a clock at one eighth of its input clock, with equal high and low times. A short feedback shift register produces a one-cycle pulse on every fourth input clock. A single toggle flop flips the divided output on each pulse, so the output is high for four input clocks and low for four.

The 3-bit shift register is not used as a free-running sequence generator. It is cut down to a four-state loop and reloaded with a fixed seed each time it reaches its last state. Its state is brought out so the loop can be watched. A synchronous reset puts the block back into its power-up condition. The divided output is a plain register output. It is meant for observation or for a pin, not as a clock for other logic in the design.

Top module: `lfsr_clk_div8`

## Requirements
- R1: While `rst` (active high, synchronous) is sampled high at a rising edge of `clk`, that edge loads `lfsr_state` with 3'b101 and clears `clk_out` to 0. `tc_pulse` is then 0.
- R2: After reset, each rising edge of `clk` moves `lfsr_state` around the loop 3'b101 → 3'b011 → 3'b110 → 3'b100 → 3'b101. The value is written as bit 2, bit 1, bit 0. The step out of 3'b100 is a reload of the seed 3'b101.
- R3: `tc_pulse` is a combinational decode that is 1 exactly when `lfsr_state` is 3'b100. After reset it is therefore high for one cycle in every four.
- R4: `clk_out` changes value at a rising edge of `clk` only when `tc_pulse` was 1 before that edge. It keeps its value at every other edge.
- R5: After reset is released, the first rising edge of `clk` is edge 1. `clk_out` first goes to 1 at edge 4.
- R6: In steady running, consecutive rising edges of `clk_out` are 8 input clocks apart. Each high phase lasts 4 input clocks.
- R7: From reset onward, `lfsr_state` never holds a value outside the set {3'b101, 3'b011, 3'b110, 3'b100}.
- R8: A reset asserted in the middle of a run takes priority over the seed reload and over the output toggle. Counting restarts from the R1 state and the R5 timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset to the power-up state |
| clk_out | output | 1 | Divided clock, input frequency / 8, 50% duty |
| tc_pulse | output | 1 | Terminal-count pulse, one cycle in four |
| lfsr_state | output | 3 | Current shift-register state |

## Verification
The bench compares state, pulse and output every cycle against a phase count kept from the requirements. It goes after the reload step, because a design that took the free-running successor of 3'b100 would leave the loop and stretch the period to seven or more clocks. It checks that the first output rise falls exactly on edge 4. An output flop that sampled the pulse one stage late, or a loop that started at the wrong seed, would show up there as an early or late rise. It also resets in the middle of a high phase, to catch a design in which a pending toggle or reload beats the reset. It measures the period and high time over many output cycles, to catch an off-by-one pulse spacing that would only show as a skewed duty cycle.

// File: rtl/lfsr_clk_div8.sv
module lfsr_clk_div8 (
  input  logic       clk,
  input  logic       rst,
  output logic       clk_out,
  output logic       tc_pulse,
  output logic [2:0] lfsr_state
);

  localparam int          W    = 3;
  localparam logic [W-1:0] SEED = 3'b101;
  localparam logic [W-1:0] LAST = 3'b100;

  logic [W-1:0] q;
  logic [W-1:0] q_nxt;
  logic         fb;
  logic         div_q;

  // XNOR feedback keeps all-zero legal; 3'b111 is the stuck state, never reached
  assign fb       = ~(q[2] ^ q[0]);
  assign tc_pulse = q[2] & ~q[1] & ~q[0];
  assign q_nxt    = tc_pulse ? SEED : {q[1:0], fb};

  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= SEED;
      div_q <= 1'b0;
    end else begin
      q     <= q_nxt;
      div_q <= div_q ^ tc_pulse;
    end
  end

  assign clk_out    = div_q;
  assign lfsr_state = q;

  assert_loop_only_R7: assert property (@(posedge clk) disable iff (rst)
    (lfsr_state == 3'b101 || lfsr_state == 3'b011 ||
     lfsr_state == 3'b110 || lfsr_state == 3'b100));

  assert_reload_R2: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |=> (lfsr_state == SEED));

  assert_first_step_R2: assert property (@(posedge clk) disable iff (rst)
    (lfsr_state == SEED) |=> (lfsr_state == 3'b011));

  assert_tc_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |=> !tc_pulse);

  assert_toggle_R4: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |=> (clk_out != $past(clk_out)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !tc_pulse |=> $stable(clk_out));

endmodule

// File: tb/lfsr_clk_div8_tb.sv
module lfsr_clk_div8_tb;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clk_out;
  logic       tc_pulse;
  logic [2:0] lfsr_state;

  int tests = 0;
  int fails = 0;
  int n     = 0;

  typedef struct {
    logic [2:0] st;
    logic       tc;
    logic       out;
    bit         in_rst;
    bit         mid;
    int         idx;
  } exp_t;

  exp_t exp_q[$];

  lfsr_clk_div8 u_dut (
    .clk(clk), .rst(rst), .clk_out(clk_out),
    .tc_pulse(tc_pulse), .lfsr_state(lfsr_state)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [2:0] loop_state(input int k);
    case (k % 4)
      0: return 3'b101;
      1: return 3'b011;
      2: return 3'b110;
      default: return 3'b100;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  bit mid_reset = 0;

  task automatic reset_cycles(input int k);
    rst = 1'b1;
    for (int i = 0; i < k; i++) begin
      exp_t e;
      @(posedge clk); #1;
      e.st = 3'b101; e.tc = 1'b0; e.out = 1'b0; e.in_rst = 1; e.mid = mid_reset; e.idx = 0;
      exp_q.push_back(e);
    end
    rst = 1'b0;
    n = 0;
  endtask

  task automatic run(input int m);
    for (int i = 0; i < m; i++) begin
      exp_t e;
      @(posedge clk); #1;
      n++;
      e.st = loop_state(n); e.tc = ((n % 4) == 3); e.out = ((n / 4) % 2) == 1;
      e.in_rst = 0; e.mid = 0; e.idx = n;
      exp_q.push_back(e);
    end
  endtask

  // monitor: scoreboard compare plus period / high-time measurement
  int  cyc = 0;
  int  last_rise = 0;
  bit  have_rise = 0;
  logic prev_out = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      if (e.in_rst) begin
        if (e.mid) begin
          check("R8 state", lfsr_state, e.st);
          check("R8 clk_out", clk_out, e.out);
        end else begin
          check("R1 state", lfsr_state, e.st);
          check("R1 clk_out", clk_out, e.out);
          check("R1 tc_pulse", tc_pulse, e.tc);
        end
      end else begin
        check("R2 state", lfsr_state, e.st);
        check("R3 tc_pulse", tc_pulse, e.tc);
        check("R4 clk_out", clk_out, e.out);
        check("R7 in loop", (lfsr_state == 3'b101 || lfsr_state == 3'b011 ||
                            lfsr_state == 3'b110 || lfsr_state == 3'b100), 1);
        if (e.idx == 3) check("R5 low before edge 4", clk_out, 0);
        if (e.idx == 4) check("R5 first rise at edge 4", clk_out, 1);
      end
    end
    if (rst) begin
      have_rise = 0;
      prev_out  = 1'b0;
    end else begin
      if (!prev_out && clk_out) begin
        if (have_rise) check("R6 period", cyc - last_rise, 8);
        have_rise = 1;
        last_rise = cyc;
      end else if (prev_out && !clk_out && have_rise) begin
        check("R6 high time", cyc - last_rise, 4);
      end
      prev_out = clk_out;
    end
  end

  bit done = 0;

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #1;
    mid_reset = 0;
    reset_cycles(3);
    run(100);
    // reset in the middle of a high phase (n=6 after run)
    run(2);
    mid_reset = 1;
    reset_cycles(1);
    mid_reset = 0;
    run(40);
    // reset right when the pulse is pending (n=3)
    reset_cycles(2);
    run(3);
    mid_reset = 1;
    reset_cycles(1);
    mid_reset = 0;
    run(60);
    @(posedge clk);
    @(negedge clk);
    #1;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule